// File: doc/BRIEF.md
# Converter Register Front End with Calibration Walker

This block sits behind the serial word port of a sampling converter. The serial shifter hands it complete 16-bit words on a write stream. The top two bits of each word name a destination, and the low 14 bits are the payload. The block keeps a control register that software can only write, a test register, and ten calibration registers. It presents a read stream whose content depends on a read-select field held in the control register. A read can return the latest conversion result, the externally supplied status word, the test register, or the calibration register under a walking pointer.

The calibration registers are ordered as gain (index 0), offset (index 1), then DAC weights 1 to 8 (indices 2 to 9). A calibration-select field in the control register chooses which part of that list is walked. Each calibration access, read or write, moves the pointer one step along the chosen part. After the last access of the sequence, the pointer returns to the start. Any control write starts the walk again.

Back-pressure rules: `wr_ready` is high in every cycle outside reset, so a word is committed in the cycle where `wr_valid` is high. `rd_valid` is also high in every cycle outside reset, and `rd_word` always shows what the next read returns. A read happens in each cycle where `rd_ready` is high, and the consumer paces the reads only through `rd_ready`.

Top module: `cvt_regfile`

## Requirements
- R1: Outside reset, `wr_ready` is 1. A word takes effect only at the clock edge where `wr_valid` and `wr_ready` are both high. Its effect is visible from the next cycle, and nothing changes while `wr_valid` is low.
- R2: Word bits 15:14 select the destination. 11 is the control register, 10 is the calibration register at the pointer, and 01 is the test register. 00 is ignored and changes neither the control register nor the test register.
- R3: The control register resets to 0. Bits 7:6 hold the read-select field and bits 5:4 hold the calibration-select field. The read-select value stays in force for every read until the next control write.
- R4: `rd_word` depends on the read-select field. 00 gives four zeros above the 12-bit result, 01 gives two zeros above the test register, 10 gives two zeros above the calibration register at the pointer, and 11 gives the status word unchanged.
- R5: Outside reset, `rd_valid` is 1 and each cycle with `rd_ready` high is one read. A read moves the pointer only when read-select is 10.
- R6: Calibration-select chooses the sequence. 00 walks indices 0 to 9, 01 uses only gain (0), 10 uses only offset (1), and 11 walks gain then offset (0, 1).
- R7: Each calibration access moves the pointer to the next index of the sequence. The access at the last index returns the pointer to the sequence start.
- R8: A control write puts the pointer at the start of the sequence named by the newly written select field, and any unfinished sequence is dropped. A read in that same cycle returns the word chosen by the old settings.
- R9: After reset, gain and offset hold 14'h2000, the DAC registers hold 0 and the test register holds 0.
- R10: A calibration write and a calibration read in the same cycle count as one access. The read returns the register's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word accepted (high outside reset) |
| wr_word | input | 16 | Destination code in bits 15:14, payload in bits 13:0 |
| rd_valid | output | 1 | Read word available (high outside reset) |
| rd_ready | input | 1 | Consumer takes the read word this cycle |
| rd_word | output | 16 | Word returned by a read |
| conv_result | input | 12 | Latest conversion result |
| status_word | input | 16 | Status word from the converter core |
| ctrl_word | output | 14 | Control register contents |
| test_word | output | 14 | Test register contents |
| cal_flat | output | 140 | All calibration registers, index 0 in the low 14 bits |

## Verification
Two things can happen in the same clock edge and both touch the pointer: a control write and a calibration read, or a calibration write and a calibration read. The bench drives `wr_valid` and `rd_ready` together in one cycle in both cases. A scoreboard judges the word read in that cycle against the old pointer position and old contents. The reads that follow are then expected to show that the pointer restarted (control write) or moved exactly once (calibration write).

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int WORD_W     = 16;
  localparam int PAY_W      = 14;
  localparam int RES_W      = 12;
  localparam int NUM_DAC    = 8;
  localparam int RDSEL_LSB  = 6;
  localparam int CALSEL_LSB = 4;
  localparam logic [PAY_W-1:0] CAL_MID = 14'h2000;

  typedef enum logic [1:0] {
    DST_NONE = 2'b00,
    DST_TEST = 2'b01,
    DST_CAL  = 2'b10,
    DST_CTRL = 2'b11
  } dst_e;

  typedef enum logic [1:0] {
    RD_RESULT = 2'b00,
    RD_TEST   = 2'b01,
    RD_CAL    = 2'b10,
    RD_STATUS = 2'b11
  } rdsel_e;

  typedef enum logic [1:0] {
    CS_ALL  = 2'b00,
    CS_GAIN = 2'b01,
    CS_OFFS = 2'b10,
    CS_PAIR = 2'b11
  } calsel_e;
endpackage

// File: rtl/cvt_wr_decode.sv
module cvt_wr_decode #(
  parameter int PAY_W = cvt_pkg::PAY_W,
  localparam int WW = PAY_W + 2
) (
  input  logic             wr_valid,
  input  logic             wr_ready,
  input  logic [WW-1:0]    wr_word,
  output logic             we_ctrl,
  output logic             we_test,
  output logic             we_cal,
  output logic [PAY_W-1:0] payload
);
  import cvt_pkg::*;
  dst_e dst;
  logic hs;

  assign hs      = wr_valid & wr_ready;
  assign dst     = dst_e'(wr_word[WW-1:PAY_W]);
  assign payload = wr_word[PAY_W-1:0];

  always_comb begin
    we_ctrl = 1'b0;
    we_test = 1'b0;
    we_cal  = 1'b0;
    if (hs) begin
      unique case (dst)
        DST_CTRL: we_ctrl = 1'b1;
        DST_TEST: we_test = 1'b1;
        DST_CAL:  we_cal  = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/cvt_cal_ptr.sv
module cvt_cal_ptr #(
  parameter int NUM_CAL = cvt_pkg::NUM_DAC + 2,
  localparam int PTR_W = $clog2(NUM_CAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [1:0]       new_sel,
  input  logic [1:0]       cur_sel,
  input  logic             access,
  output logic [PTR_W-1:0] ptr
);
  import cvt_pkg::*;

  function automatic logic [PTR_W-1:0] seq_start(input logic [1:0] sel);
    return (calsel_e'(sel) == CS_OFFS) ? PTR_W'(1) : PTR_W'(0);
  endfunction

  function automatic logic [PTR_W-1:0] seq_last(input logic [1:0] sel);
    unique case (calsel_e'(sel))
      CS_ALL:  return PTR_W'(NUM_CAL - 1);
      CS_GAIN: return PTR_W'(0);
      CS_OFFS: return PTR_W'(1);
      default: return PTR_W'(1);
    endcase
  endfunction

  logic [PTR_W-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr;
    if (ctrl_wr)
      ptr_nxt = seq_start(new_sel);
    else if (access)
      ptr_nxt = (ptr == seq_last(cur_sel)) ? seq_start(cur_sel) : ptr + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end
endmodule

// File: rtl/cvt_cal_bank.sv
module cvt_cal_bank #(
  parameter int NUM_CAL = cvt_pkg::NUM_DAC + 2,
  parameter int PAY_W   = cvt_pkg::PAY_W,
  localparam int PTR_W  = $clog2(NUM_CAL)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [PTR_W-1:0]         ptr,
  input  logic [PAY_W-1:0]         wdata,
  output logic [PAY_W-1:0]         rdata,
  output logic [NUM_CAL*PAY_W-1:0] cal_flat
);
  logic [PAY_W-1:0] regs [NUM_CAL];

  for (genvar g = 0; g < NUM_CAL; g++) begin : g_reg
    localparam logic [PAY_W-1:0] RST_VAL = (g < 2) ? cvt_pkg::CAL_MID : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         regs[g] <= RST_VAL;
      else if (we && ptr == PTR_W'(g))    regs[g] <= wdata;
    end
    assign cal_flat[g*PAY_W +: PAY_W] = regs[g];
  end

  assign rdata = regs[ptr];
endmodule

// File: rtl/cvt_rd_mux.sv
module cvt_rd_mux #(
  parameter int PAY_W = cvt_pkg::PAY_W,
  parameter int RES_W = cvt_pkg::RES_W,
  localparam int WW = PAY_W + 2
) (
  input  logic [1:0]       rd_sel,
  input  logic [RES_W-1:0] result,
  input  logic [PAY_W-1:0] test_val,
  input  logic [PAY_W-1:0] cal_val,
  input  logic [WW-1:0]    status,
  output logic [WW-1:0]    word
);
  import cvt_pkg::*;
  always_comb begin
    unique case (rdsel_e'(rd_sel))
      RD_RESULT: word = {{(WW-RES_W){1'b0}}, result};
      RD_TEST:   word = {2'b00, test_val};
      RD_CAL:    word = {2'b00, cal_val};
      default:   word = status;
    endcase
  end
endmodule

// File: rtl/cvt_regfile.sv
module cvt_regfile #(
  parameter int NUM_DAC = cvt_pkg::NUM_DAC,
  parameter int PAY_W   = cvt_pkg::PAY_W,
  parameter int RES_W   = cvt_pkg::RES_W,
  localparam int NUM_CAL = NUM_DAC + 2,
  localparam int PTR_W   = $clog2(NUM_CAL),
  localparam int WW      = PAY_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [WW-1:0]            wr_word,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic [WW-1:0]            rd_word,
  input  logic [RES_W-1:0]         conv_result,
  input  logic [WW-1:0]            status_word,
  output logic [PAY_W-1:0]         ctrl_word,
  output logic [PAY_W-1:0]         test_word,
  output logic [NUM_CAL*PAY_W-1:0] cal_flat
);
  import cvt_pkg::*;

  logic             we_ctrl, we_test, we_cal;
  logic [PAY_W-1:0] payload;
  logic [PAY_W-1:0] ctrl_q, test_q, cal_rdata;
  logic [PTR_W-1:0] cal_ptr;
  logic [1:0]       rd_sel, cal_sel;
  logic             cal_rd, cal_access;

  assign wr_ready = rst_n;
  assign rd_valid = rst_n;

  cvt_wr_decode #(.PAY_W(PAY_W)) u_dec (
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_word  (wr_word),
    .we_ctrl  (we_ctrl),
    .we_test  (we_test),
    .we_cal   (we_cal),
    .payload  (payload)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      test_q <= '0;
    end else begin
      if (we_ctrl) ctrl_q <= payload;
      if (we_test) test_q <= payload;
    end
  end

  assign rd_sel     = ctrl_q[RDSEL_LSB +: 2];
  assign cal_sel    = ctrl_q[CALSEL_LSB +: 2];
  assign cal_rd     = rd_valid && rd_ready && (rdsel_e'(rd_sel) == RD_CAL);
  assign cal_access = we_cal | cal_rd;

  cvt_cal_ptr #(.NUM_CAL(NUM_CAL)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (we_ctrl),
    .new_sel (payload[CALSEL_LSB +: 2]),
    .cur_sel (cal_sel),
    .access  (cal_access),
    .ptr     (cal_ptr)
  );

  cvt_cal_bank #(.NUM_CAL(NUM_CAL), .PAY_W(PAY_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we_cal),
    .ptr      (cal_ptr),
    .wdata    (payload),
    .rdata    (cal_rdata),
    .cal_flat (cal_flat)
  );

  cvt_rd_mux #(.PAY_W(PAY_W), .RES_W(RES_W)) u_mux (
    .rd_sel   (rd_sel),
    .result   (conv_result),
    .test_val (test_q),
    .cal_val  (cal_rdata),
    .status   (status_word),
    .word     (rd_word)
  );

  assign ctrl_word = ctrl_q;
  assign test_word = test_q;
endmodule

// File: rtl/cvt_regfile_chk.sv
module cvt_regfile_chk #(
  parameter int PAY_W   = 14,
  parameter int NUM_CAL = 10,
  parameter int PTR_W   = 4,
  localparam int WW = PAY_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [WW-1:0]    wr_word,
  input logic [WW-1:0]    rd_word,
  input logic [PAY_W-1:0] ctrl_word,
  input logic [PAY_W-1:0] test_word,
  input logic [PTR_W-1:0] ptr
);
  logic ctrl_hs, none_hs;
  assign ctrl_hs = wr_valid && wr_ready && wr_word[WW-1 -: 2] == 2'b11;
  assign none_hs = wr_valid && wr_ready && wr_word[WW-1 -: 2] == 2'b00;

  a_r2_zero_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    none_hs |=> $stable(ctrl_word) && $stable(test_word));
  a_r3_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_hs |=> $stable(ctrl_word));
  a_r3_ctrl_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hs |=> ctrl_word == $past(wr_word[PAY_W-1:0]));
  a_r4_result_pad: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[7:6] == 2'b00 |-> rd_word[WW-1 -: 4] == 4'h0);
  a_r4_cal_pad: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[7:6] == 2'b10 |-> rd_word[WW-1 -: 2] == 2'b00);
  a_r6_gain_only: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[5:4] == 2'b01 |-> ptr == '0);
  a_r6_offs_only: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[5:4] == 2'b10 |-> ptr == PTR_W'(1));
  a_r6_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[5:4] == 2'b11 |-> ptr <= PTR_W'(1));
  a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PTR_W'(NUM_CAL));
  a_r8_ctrl_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hs && wr_word[5:4] != 2'b10) |=> ptr == '0);
endmodule

bind cvt_regfile cvt_regfile_chk #(.PAY_W(PAY_W), .NUM_CAL(NUM_CAL), .PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_word   (wr_word),
  .rd_word   (rd_word),
  .ctrl_word (ctrl_word),
  .test_word (test_word),
  .ptr       (cal_ptr)
);

// File: tb/cvt_regfile_tb.sv
module cvt_regfile_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [15:0]  wr_word = '0;
  logic         rd_valid;
  logic         rd_ready = 1'b0;
  logic [15:0]  rd_word;
  logic [11:0]  conv_result = 12'hA5C;
  logic [15:0]  status_word = 16'h1234;
  logic [13:0]  ctrl_word, test_word;
  logic [139:0] cal_flat;

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  cvt_regfile u_dut (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_word, .rd_valid, .rd_ready,
    .rd_word, .conv_result, .status_word, .ctrl_word, .test_word, .cal_flat
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk);
    wr_valid = 1'b1; wr_word = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_ready = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic both(input logic [15:0] w, input logic [15:0] exp, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_word = w; rd_ready = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    wr_valid = 1'b0; rd_ready = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rd_valid && rd_ready) begin
      if (exp_q.size() == 0) chk("unexpected read", 32'(rd_word), 32'hFFFF_FFFF);
      else chk(tag_q.pop_front(), 32'(rd_word), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr_ready", 32'(wr_ready), 1);
    chk("R5 rd_valid", 32'(rd_valid), 1);
    chk("R3 ctrl reset", 32'(ctrl_word), 0);
    chk("R9 test reset", 32'(test_word), 0);
    chk("R9 gain reset", 32'(cal_flat[13:0]), 32'h2000);
    rd(16'h0A5C, "R4 result pad");
    // R1: held word without valid does nothing
    @(negedge clk); wr_word = 16'hC0C0; @(negedge clk);
    chk("R1 no commit without valid", 32'(ctrl_word), 0);
    // read-select status
    wr(16'hC0C0);
    chk("R3 ctrl write", 32'(ctrl_word), 32'h00C0);
    rd(16'h1234, "R4 status");
    rd(16'h1234, "R3 persist");
    status_word = 16'hBEEF;
    rd(16'hBEEF, "R3 persist new status");
    // R2 code 00 ignored
    wr(16'h3FFF);
    chk("R2 ignored ctrl", 32'(ctrl_word), 32'h00C0);
    chk("R2 ignored test", 32'(test_word), 0);
    rd(16'hBEEF, "R2 ignored read");
    // test register
    wr(16'h5ABC);
    chk("R2 test write", 32'(test_word), 32'h1ABC);
    wr(16'hC040);
    rd(16'h1ABC, "R4 test read");
    // calibration reset values, full walk with wrap
    wr(16'hC080);
    rd(16'h2000, "R9 gain");
    rd(16'h2000, "R9 offset");
    for (int i = 0; i < 8; i++) rd(16'h0000, "R9 dac");
    rd(16'h2000, "R7 wrap to gain");
    // write all ten then read back in order
    wr(16'hC080);
    for (int i = 0; i < 10; i++) wr(16'h8100 + 16'(i));
    for (int i = 0; i < 10; i++) rd(16'h0100 + 16'(i), "R6 order all");
    // gain only
    wr(16'hC090);
    rd(16'h0100, "R6 gain only");
    rd(16'h0100, "R7 gain only stays");
    wr(16'h8AAA);
    rd(16'h0AAA, "R6 gain only write");
    // offset only
    wr(16'hC0A0);
    rd(16'h0101, "R6 offset only");
    rd(16'h0101, "R7 offset only stays");
    // pair
    wr(16'hC0B0);
    rd(16'h0AAA, "R6 pair gain");
    rd(16'h0101, "R6 pair offset");
    rd(16'h0AAA, "R7 pair wrap");
    // abandon mid-sequence
    wr(16'hC080);
    rd(16'h0AAA, "R8 walk 0");
    rd(16'h0101, "R8 walk 1");
    rd(16'h0102, "R8 walk 2");
    wr(16'hC080);
    rd(16'h0AAA, "R8 restart");
    rd(16'h0101, "R8 walk again");
    // control write with calibration read in same cycle
    both(16'hC0B0, 16'h0102, "R8 same-cycle old pointer");
    rd(16'h0AAA, "R8 same-cycle restart");
    // calibration write with calibration read in same cycle
    both(16'h8555, 16'h0101, "R10 same-cycle old data");
    rd(16'h0AAA, "R10 one step");
    rd(16'h0555, "R10 written");
    // result reads leave the pointer alone
    wr(16'hC000);
    conv_result = 12'hFFF;
    rd(16'h0FFF, "R4 result full");
    rd(16'h0FFF, "R5 result again");
    wr(16'h8123);
    chk("R5 pointer still at gain", 32'(cal_flat[13:0]), 32'h0123);
    wr(16'hC080);
    rd(16'h0123, "R5 gain readback");
    repeat (3) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule